// File: doc/BRIEF.md
# Per-Channel Video Gain with Pushbutton Stepping

This block scales each 8-bit red, green and blue sample of a pixel stream by its own gain. A gain is a 9-bit unsigned fixed-point number with one integer bit and eight fraction bits, so a code of 256 means unity. The colour sample is widened to 9 bits with a zero on top, multiplied by its gain, and the output colour is the eight bits that sit just above the fraction, which is the integer part of the scaled sample.

The three gains live inside the block and are changed at run time from front-panel style inputs: a three-bit channel select, a direction bit and a debounced pushbutton level. Each press moves every selected gain by one fraction step, clamped to the range 0 to unity. The vertical sync, horizontal sync and data-enable qualifiers travel through a delay line of the same length as the colour path, so they stay aligned with the scaled pixels.

Top module: `rgb_gain_adj`

## Requirements
- R1: After reset every gain is unity (code 256), so once the pipeline has filled each output colour equals its input colour, and during reset all outputs are 0.
- R2: Each output colour equals bits 15:8 of the product of the zero-extended 9-bit input colour and that channel's 9-bit gain, i.e. floor(colour * gain / 256).
- R3: A colour sample applied before clock edge k appears at the output after edge k+1 (two-cycle latency); after edge k alone the output still shows the earlier result.
- R4: vsync_o, hsync_o and de_o reproduce vsync_i, hsync_i and de_i with the same two-cycle latency as the colours.
- R5: On a low-to-high transition of btn_i each selected gain moves one step (1/256): up when up_i is 1, down when up_i is 0.
- R6: Holding btn_i high for several cycles produces exactly one step.
- R7: A gain whose select bit is 0 is unchanged by a press.
- R8: A gain never exceeds unity; an up press at unity leaves it at 256.
- R9: A gain never drops below 0; a down press at 0 leaves it at 0.
- R10: Select bit 0 addresses the red gain, bit 1 green, bit 2 blue; several bits may be set at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| r_i | input | 8 | Red sample in |
| g_i | input | 8 | Green sample in |
| b_i | input | 8 | Blue sample in |
| vsync_i | input | 1 | Vertical sync in |
| hsync_i | input | 1 | Horizontal sync in |
| de_i | input | 1 | Data enable in |
| sel_i | input | 3 | Gain select: bit 0 red, bit 1 green, bit 2 blue |
| up_i | input | 1 | Step direction: 1 up, 0 down |
| btn_i | input | 1 | Debounced pushbutton level; rising edge applies a step |
| r_o | output | 8 | Scaled red sample |
| g_o | output | 8 | Scaled green sample |
| b_o | output | 8 | Scaled blue sample |
| vsync_o | output | 1 | Delayed vertical sync |
| hsync_o | output | 1 | Delayed horizontal sync |
| de_o | output | 1 | Delayed data enable |

## Verification
A gain that is off by even one step shows at the ports two cycles after the next pixel: with a full-scale sample of 255 the output reads one below the gain code, so the bench reads gains back through the colour path. A gain that silently passed unity is invisible for one step at full scale, so the cap is proven by pressing up at unity and then down once, which exposes the stored value. A wrapped gain at zero is caught the same way by stepping down past zero and back up twice. Misaligned syncs show up as a flag arriving one cycle early or late against the scaled colour.

// File: rtl/rgb_gain_pkg.sv
package rgb_gain_pkg;
  localparam int PIX_W   = 8;
  localparam int FRAC_W  = 8;
  localparam int GAIN_W  = FRAC_W + 1;
  localparam int N_CH    = 3;
  localparam int SYNC_W  = 3;
  localparam int MUL_LAT = 2;
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << FRAC_W;

  typedef enum int {CH_R = 0, CH_G = 1, CH_B = 2} chan_e;
endpackage

// File: rtl/gain_step_ctrl.sv
module gain_step_ctrl #(
  parameter int N_CH   = 3,
  parameter int GAIN_W = 9,
  parameter logic [GAIN_W-1:0] GAIN_MAX = 9'd256
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_CH-1:0]               sel_i,
  input  logic                          up_i,
  input  logic                          btn_i,
  output logic [N_CH-1:0][GAIN_W-1:0]   gain_o
);
  logic btn_q;
  logic step;

  assign step = btn_i & ~btn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) btn_q <= 1'b0;
    else         btn_q <= btn_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_CH; c++) gain_o[c] <= GAIN_MAX;
    end else if (step) begin
      for (int c = 0; c < N_CH; c++) begin
        if (sel_i[c]) begin
          if (up_i && gain_o[c] < GAIN_MAX)       gain_o[c] <= gain_o[c] + 1'b1;
          else if (!up_i && gain_o[c] != '0)      gain_o[c] <= gain_o[c] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gain_lane.sv
module gain_lane #(
  parameter int PIX_W  = 8,
  parameter int GAIN_W = 9,
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [PIX_W-1:0]  pix_o
);
  localparam int EXT_W  = PIX_W + 1;
  localparam int PROD_W = EXT_W + GAIN_W;

  logic [PIX_W-1:0]  pix_q;
  logic [PROD_W-1:0] prod;

  // zero-extended operand keeps the multiply unsigned
  assign prod = PROD_W'({1'b0, pix_q}) * PROD_W'(gain_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      pix_o <= '0;
    end else begin
      pix_q <= pix_i;
      pix_o <= PIX_W'(prod >> FRAC_W);
    end
  end
endmodule

// File: rtl/sync_delay.sv
module sync_delay #(
  parameter int W     = 3,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [DEPTH-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/rgb_gain_adj.sv
module rgb_gain_adj
  import rgb_gain_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  input  logic             vsync_i,
  input  logic             hsync_i,
  input  logic             de_i,
  input  logic [N_CH-1:0]  sel_i,
  input  logic             up_i,
  input  logic             btn_i,
  output logic [PIX_W-1:0] r_o,
  output logic [PIX_W-1:0] g_o,
  output logic [PIX_W-1:0] b_o,
  output logic             vsync_o,
  output logic             hsync_o,
  output logic             de_o
);
  logic [N_CH-1:0][GAIN_W-1:0] gain_w;
  logic [PIX_W-1:0]            pix_in  [N_CH];
  logic [PIX_W-1:0]            pix_out [N_CH];

  assign pix_in[CH_R] = r_i;
  assign pix_in[CH_G] = g_i;
  assign pix_in[CH_B] = b_i;

  gain_step_ctrl #(
    .N_CH(N_CH), .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_ONE)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i),
    .up_i(up_i), .btn_i(btn_i), .gain_o(gain_w)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    gain_lane #(
      .PIX_W(PIX_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)
    ) u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .pix_i(pix_in[c]),
      .gain_i(gain_w[c]), .pix_o(pix_out[c])
    );
  end

  sync_delay #(.W(SYNC_W), .DEPTH(MUL_LAT)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({vsync_i, hsync_i, de_i}),
    .q_o({vsync_o, hsync_o, de_o})
  );

  assign r_o = pix_out[CH_R];
  assign g_o = pix_out[CH_G];
  assign b_o = pix_out[CH_B];
endmodule

// File: rtl/rgb_gain_adj_chk.sv
module rgb_gain_adj_chk
  import rgb_gain_pkg::*;
(
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [PIX_W-1:0]            r_i,
  input logic [PIX_W-1:0]            r_o,
  input logic [SYNC_W-1:0]           sync_i,
  input logic [SYNC_W-1:0]           sync_o,
  input logic [N_CH-1:0]             sel_i,
  input logic                        btn_i,
  input logic [N_CH-1:0][GAIN_W-1:0] gain_w
);
  localparam int PW = PIX_W + 1 + GAIN_W;

  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 1'b1;
  end

  // R4: qualifiers aligned to the colour latency
  a_r4_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2) |-> sync_o == $past(sync_i, 2));

  // R2: red output from sample two edges back and gain one edge back
  a_r2_red_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2) |-> r_o == PIX_W'((PW'($past(r_i, 2)) * PW'($past(gain_w[0]))) >> FRAC_W));

  // R6: held button gives no further step
  a_r6_held_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 1 && btn_i && $past(btn_i)) |=> $stable(gain_w));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    // R8: never above unity
    a_r8_gain_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gain_w[c] <= GAIN_ONE);
    // R7: unselected channel holds
    a_r7_unselected_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i[c] |=> gain_w[c] == $past(gain_w[c]));
    // R5: at most one step per cycle
    a_r5_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc >= 1) |-> (gain_w[c] == $past(gain_w[c]) ||
                      gain_w[c] == $past(gain_w[c]) + 1'b1 ||
                      gain_w[c] == $past(gain_w[c]) - 1'b1));
  end
endmodule

bind rgb_gain_adj rgb_gain_adj_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .r_i(r_i), .r_o(r_o),
  .sync_i({vsync_i, hsync_i, de_i}), .sync_o({vsync_o, hsync_o, de_o}),
  .sel_i(sel_i), .btn_i(btn_i), .gain_w(gain_w)
);

// File: tb/rgb_gain_adj_tb.sv
module rgb_gain_adj_tb;
  localparam time CLK_T = 10ns;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] r_i = '0, g_i = '0, b_i = '0;
  logic       vsync_i = 1'b0, hsync_i = 1'b0, de_i = 1'b0;
  logic [2:0] sel_i = '0;
  logic       up_i = 1'b0, btn_i = 1'b0;
  logic [7:0] r_o, g_o, b_o;
  logic       vsync_o, hsync_o, de_o;

  int n_chk = 0, n_bad = 0;
  int gm[3] = '{256, 256, 256};

  always #(CLK_T/2) clk_i = ~clk_i;

  rgb_gain_adj u_dut (.*);

  typedef struct packed {
    logic [7:0] r, g, b;
    logic [2:0] s;
    logic [7:0] er, eg, eb;
  } vec_t;

  // gains during the table: R 255, G 128, B 256
  localparam vec_t VECS[6] = '{
    '{8'd0,   8'd0,   8'd0,   3'b000, 8'd0,   8'd0,   8'd0},
    '{8'd255, 8'd255, 8'd255, 3'b111, 8'd254, 8'd127, 8'd255},
    '{8'd128, 8'd1,   8'd77,  3'b101, 8'd127, 8'd0,   8'd77},
    '{8'd1,   8'd200, 8'd16,  3'b010, 8'd0,   8'd100, 8'd16},
    '{8'd100, 8'd3,   8'd254, 3'b001, 8'd99,  8'd1,   8'd254},
    '{8'd200, 8'd129, 8'd0,   3'b100, 8'd199, 8'd64,  8'd0}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int scale(int p, int g);
    return (p * g) / 256;
  endfunction

  task automatic press(logic [2:0] s, logic u);
    @(negedge clk_i);
    sel_i = s; up_i = u; btn_i = 1'b1;
    for (int c = 0; c < 3; c++)
      if (s[c]) begin
        if (u && gm[c] < 256)       gm[c]++;
        else if (!u && gm[c] > 0)   gm[c]--;
      end
    @(negedge clk_i);
    btn_i = 1'b0;
    sel_i = '0;
    @(negedge clk_i);
  endtask

  task automatic read_px(string req, int pr, int pg, int pb);
    @(negedge clk_i);
    r_i = 8'(pr); g_i = 8'(pg); b_i = 8'(pb);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    check({req, " red"},   r_o, scale(pr, gm[0]));
    check({req, " green"}, g_o, scale(pg, gm[1]));
    check({req, " blue"},  b_o, scale(pb, gm[2]));
  endtask

  initial begin
    #(CLK_T * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #(CLK_T * 2);
    check("R1 reset red", r_o, 0);
    check("R1 reset de", de_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    read_px("R1 unity", 200, 17, 255);

    // set gains R=255, G=128 for the table
    press(3'b001, 1'b0);
    for (int i = 0; i < 128; i++) press(3'b010, 1'b0);

    // R2/R4 table walk, sampled exactly two edges after drive (R3)
    foreach (VECS[i]) begin
      @(negedge clk_i);
      r_i = VECS[i].r; g_i = VECS[i].g; b_i = VECS[i].b;
      {vsync_i, hsync_i, de_i} = VECS[i].s;
      repeat (2) @(posedge clk_i);
      @(negedge clk_i);
      check("R2 red", r_o, VECS[i].er);
      check("R2 green", g_o, VECS[i].eg);
      check("R2 blue", b_o, VECS[i].eb);
      check("R4 sync", {vsync_o, hsync_o, de_o}, VECS[i].s);
    end
    @(negedge clk_i);
    {vsync_i, hsync_i, de_i} = 3'b000;

    // R6: held button, one step only; R7: others unchanged
    @(negedge clk_i);
    sel_i = 3'b001; up_i = 1'b0; btn_i = 1'b1;
    repeat (5) @(negedge clk_i);
    btn_i = 1'b0; sel_i = '0;
    gm[0] = 254;
    read_px("R6 R7 held", 255, 255, 255);
    check("R6 red", r_o, 253);
    check("R7 green", g_o, 127);

    // R5/R10: all three selected, step up
    press(3'b111, 1'b1);
    read_px("R5 R10 multi", 255, 255, 255);
    check("R10 green", g_o, 128);

    // R8: up at unity stays, then one down exposes 255
    press(3'b100, 1'b1);
    press(3'b100, 1'b1);
    press(3'b100, 1'b0);
    read_px("R8 cap", 255, 255, 255);
    check("R8 blue", b_o, 254);

    // R9: down past zero, then two up -> gain 2
    for (int i = 0; i < 131; i++) press(3'b010, 1'b0);
    press(3'b010, 1'b1);
    press(3'b010, 1'b1);
    read_px("R9 floor", 255, 255, 255);
    check("R9 green", g_o, 1);

    // R3/R4: exact latency
    @(negedge clk_i);
    r_i = 8'd10; vsync_i = 1'b1; de_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R3 red one edge", r_o, scale(255, gm[0]));
    check("R4 vsync one edge", vsync_o, 0);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R3 red two edges", r_o, scale(10, gm[0]));
    check("R4 vsync two edges", vsync_o, 1);
    check("R4 de two edges", de_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule